// File: doc/BRIEF.md
# Virtual Address Translator with Table Walker

This block turns 32-bit virtual addresses from a processor-side request port into physical addresses. Pages are 4 KB: the low 12 address bits go straight through as the page offset, and the upper 20 bits are the virtual page number (VPN). An eight-slot, fully associative buffer of recent page table entries is searched first. When the search finds the VPN, the block answers without touching memory.

When the search misses, the block reads one page table entry itself. It forms the entry address from a page table base register and the VPN, and it reads the entry through a simple memory request/response port. A present entry is installed into the buffer and the translation completes. An absent entry produces a page fault response, and nothing is installed. Each slot keeps a used flag and a modified flag, and the response reports both. A context switch rewrites the base register, which also empties the buffer. Software writes the base register only while no translation is outstanding.

Top module: `va_xlate_top`

## Requirements
- R1: A successful response carries `rsp_paddr` = {20-bit frame number, `req_vaddr[11:0]`}. The frame number is page table entry bits 19:0.
- R2: A request whose VPN is resident gets its response (`rsp_valid` high) in the cycle after acceptance, and it issues no memory read.
- R3: A miss issues exactly one memory read, at address base + 4*VPN. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen.
- R4: A miss answers one cycle after `mem_rsp_valid` is sampled. When entry bit 31 (present) is 1, the entry is installed, so the next access to that VPN hits.
- R5: When entry bit 31 is 0, the response has `rsp_fault`=1 and `rsp_paddr`, `rsp_ref` and `rsp_dirty` all 0. Nothing is installed, so a repeat access reads memory again.
- R6: Every successful response has `rsp_ref`=1. `rsp_dirty` equals entry bit 30 ORed with every write made to that slot since it was installed. Entry bit 29 is ignored.
- R7: Empty slots are used before any resident entry is replaced: eight distinct installs after a flush all stay resident.
- R8: When all slots are full, an install replaces one resident entry. The slot is picked by a free-running 16-bit LFSR, and the new entry is resident afterwards.
- R9: A `base_wr_en` pulse loads the base register and empties the buffer. `req_ready` is low in that cycle, and later misses read from the new base.
- R10: `req_ready` stays low from the acceptance of a miss until its response cycle, so only one translation is ever in flight.
- R11: After reset the buffer is empty, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store (sets modified flag) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Page fault for this request |
| rsp_paddr | output | 32 | Physical address |
| rsp_ref | output | 1 | Used flag of the entry after this access |
| rsp_dirty | output | 1 | Modified flag of the entry after this access |
| mem_req_valid | output | 1 | Page table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Page table entry |
| base_wr_en | input | 1 | Load base register and flush |
| base_wr_data | input | 32 | New base register value |

## Verification
Several rules are checked on every cycle:
- at most one slot matches a VPN;
- a flush leaves no live slot;
- the LFSR never reaches zero;
- a hit answers the next cycle with no memory request;
- the memory request holds steady under backpressure;
- a miss blocks further requests;
- fault responses carry zeroed fields.

Other behaviour only the bench's scenarios can show: the computed entry addresses, frame and offset formation, how the modified flag builds up across writes, the fill order of empty slots, eviction when the buffer is full, and invalidation after the base register is rewritten.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;
  localparam int VA_W     = 32;
  localparam int PG_OFF_W = 12;
  localparam int VPN_W    = VA_W - PG_OFF_W;
  localparam int PFN_W    = VA_W - PG_OFF_W;

  // page table entry layout (decoded by the walk)
  localparam int PTE_PRESENT_BIT = 31;
  localparam int PTE_DIRTY_BIT   = 30;

  typedef struct packed {
    logic             live;
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    logic             used;
    logic             mod;
  } slot_t;

  typedef enum logic [1:0] {WK_IDLE, WK_ISSUE, WK_AWAIT} walk_st_t;
endpackage

// File: rtl/xlate_lfsr.sv
`timescale 1ns/1ps
module xlate_lfsr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] TAPS = 'hB400,
  parameter logic [W-1:0] SEED = 'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  // Galois form, advances every cycle
  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else if (state[0]) state <= (state >> 1) ^ TAPS;
    else state <= state >> 1;
  end

  p_lfsr_nonzero_r8: assert property (@(posedge clk) disable iff (rst) state != '0)
    else $error("lfsr reached zero");
endmodule

// File: rtl/xlate_slot_array.sv
`timescale 1ns/1ps
module xlate_slot_array
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_upd,
  input  logic             lk_wr,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_mod,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PFN_W-1:0] ins_pfn,
  input  logic             ins_mod,
  input  logic [IDX_W-1:0] rnd_idx
);
  slot_t slots [ENTRIES];
  logic [ENTRIES-1:0] match_v;
  logic [ENTRIES-1:0] live_v;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   victim;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign live_v[g]  = slots[g].live;
    assign match_v[g] = slots[g].live && (slots[g].vpn == lk_vpn);
  end

  // match vector is one-hot or empty, so an OR-mux suffices
  always_comb begin
    lk_hit = |match_v;
    lk_pfn = '0;
    lk_mod = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_v[i]) begin
        lk_pfn = lk_pfn | slots[i].pfn;
        lk_mod = lk_mod | slots[i].mod;
      end
    end
  end

  // lowest empty slot first, LFSR pick only when full
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!live_v[i]) free_idx = IDX_W'(i);
    end
    victim = (&live_v) ? rnd_idx : free_idx;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < ENTRIES; i++) slots[i].live <= 1'b0;
    end else begin
      if (lk_upd) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (match_v[i]) begin
            slots[i].used <= 1'b1;
            if (lk_wr) slots[i].mod <= 1'b1;
          end
        end
      end
      if (ins_en) begin
        slots[victim].live <= 1'b1;
        slots[victim].vpn  <= ins_vpn;
        slots[victim].pfn  <= ins_pfn;
        slots[victim].used <= 1'b1;
        slots[victim].mod  <= ins_mod;
      end
    end
  end

  p_single_match_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(match_v))
    else $error("duplicate vpn in buffer");
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst) flush |=> (live_v == '0))
    else $error("slot live after flush");
  p_install_live_r4: assert property (@(posedge clk) disable iff (rst)
    (ins_en && !flush) |=> (live_v != '0))
    else $error("install left buffer empty");
endmodule

// File: rtl/va_xlate_top.sv
`timescale 1ns/1ps
module va_xlate_top
  import xlate_pkg::*;
#(
  parameter int                ENTRIES   = 8,
  parameter int                LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 'hACE1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_ref,
  output logic            rsp_dirty,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [VA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  input  logic            base_wr_en,
  input  logic [VA_W-1:0] base_wr_data
);
  localparam int IDX_W = $clog2(ENTRIES);

  walk_st_t              st;
  logic [VA_W-1:0]       pt_base;
  logic [VPN_W-1:0]      hold_vpn;
  logic [PG_OFF_W-1:0]   hold_off;
  logic                  hold_wr;
  logic                  accept;
  logic                  lk_hit;
  logic                  lk_mod;
  logic [PFN_W-1:0]      lk_pfn;
  logic                  ins_en;
  logic                  pte_present;
  logic [LFSR_W-1:0]     rnd;
  logic [VPN_W-1:0]      req_vpn;

  assign req_vpn     = req_vaddr[VA_W-1:PG_OFF_W];
  assign req_ready   = (st == WK_IDLE) && !base_wr_en;
  assign accept      = req_valid && req_ready;
  assign pte_present = mem_rsp_data[PTE_PRESENT_BIT];
  assign ins_en      = (st == WK_AWAIT) && mem_rsp_valid && pte_present;

  xlate_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_rng (
    .clk(clk), .rst(rst), .state(rnd)
  );

  xlate_slot_array #(.ENTRIES(ENTRIES)) u_slots (
    .clk(clk), .rst(rst), .flush(base_wr_en),
    .lk_vpn(req_vpn), .lk_upd(accept), .lk_wr(req_write),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_mod(lk_mod),
    .ins_en(ins_en), .ins_vpn(hold_vpn), .ins_pfn(mem_rsp_data[PFN_W-1:0]),
    .ins_mod(mem_rsp_data[PTE_DIRTY_BIT] | hold_wr),
    .rnd_idx(rnd[IDX_W-1:0])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= WK_IDLE;
      pt_base       <= '0;
      hold_vpn      <= '0;
      hold_off      <= '0;
      hold_wr       <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_ref       <= 1'b0;
      rsp_dirty     <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (base_wr_en) pt_base <= base_wr_data;
      case (st)
        WK_IDLE: begin
          if (accept) begin
            hold_vpn <= req_vpn;
            hold_off <= req_vaddr[PG_OFF_W-1:0];
            hold_wr  <= req_write;
            if (lk_hit) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_paddr <= {lk_pfn, req_vaddr[PG_OFF_W-1:0]};
              rsp_ref   <= 1'b1;
              rsp_dirty <= lk_mod | req_write;
            end else begin
              st            <= WK_ISSUE;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= pt_base + (VA_W'(req_vpn) << 2);
            end
          end
        end
        WK_ISSUE: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            st            <= WK_AWAIT;
          end
        end
        WK_AWAIT: begin
          if (mem_rsp_valid) begin
            st        <= WK_IDLE;
            rsp_valid <= 1'b1;
            rsp_fault <= !pte_present;
            if (pte_present) begin
              rsp_paddr <= {mem_rsp_data[PFN_W-1:0], hold_off};
              rsp_ref   <= 1'b1;
              rsp_dirty <= mem_rsp_data[PTE_DIRTY_BIT] | hold_wr;
            end else begin
              rsp_paddr <= '0;
              rsp_ref   <= 1'b0;
              rsp_dirty <= 1'b0;
            end
          end
        end
        default: st <= WK_IDLE;
      endcase
    end
  end

  p_hit_next_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && lk_hit) |=> (rsp_valid && !mem_req_valid))
    else $error("hit did not answer next cycle");
  p_memreq_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
    else $error("memory request dropped or changed");
  p_walk_answer_r4: assert property (@(posedge clk) disable iff (rst)
    (st == WK_AWAIT && mem_rsp_valid) |=> rsp_valid)
    else $error("walk did not answer");
  p_fault_clean_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_ref && !rsp_dirty))
    else $error("fault response not clean");
  p_used_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> rsp_ref)
    else $error("used flag clear on success");
  p_miss_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    (accept && !lk_hit) |=> !req_ready)
    else $error("request port open during walk");
endmodule

// File: tb/va_xlate_top_tb.sv
`timescale 1ns/1ps
module va_xlate_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_fault, rsp_ref, rsp_dirty;
  logic [31:0] rsp_paddr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mem_reqs = 0;
  int rsp_drive_cyc = 0;
  int exp_vpn = 0;
  logic [31:0] exp_base = '0;
  bit dmod [0:63];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  va_xlate_top dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rsp_ref(rsp_ref), .rsp_dirty(rsp_dirty),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data)
  );

  function automatic logic [31:0] pte_of(int v);
    logic [31:0] p;
    p = '0;
    p[31] = (v % 11) != 10;
    p[30] = (v % 3) == 2;
    p[19:0] = 20'(v * 37 + 3);
    return p;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: stalls ready by vpn%3 cycles, answers two cycles later
  initial begin
    int mst = 0;
    int stall = 0;
    int wait_n = 0;
    logic [31:0] pend;
    pend = '0;
    forever begin
      @(negedge clk);
      case (mst)
        0: if (mem_req_valid) begin
             mem_reqs++;
             chk(mem_req_addr == exp_base + 32'(exp_vpn * 4), "R3 entry address",
                 64'(mem_req_addr), 64'(exp_base + 32'(exp_vpn * 4)));
             pend = pte_of(exp_vpn);
             stall = exp_vpn % 3;
             mst = 1;
           end
        1: if (stall == 0) begin mem_req_ready = 1'b1; mst = 2; end
           else stall--;
        2: begin mem_req_ready = 1'b0; wait_n = 1; mst = 3; end
        3: if (wait_n == 0) begin
             mem_rsp_valid = 1'b1; mem_rsp_data = pend; rsp_drive_cyc = cyc; mst = 4;
           end else wait_n--;
        default: begin mem_rsp_valid = 1'b0; mem_rsp_data = '0; mst = 0; end
      endcase
    end
  end

  // mode: 0 expect miss, 1 expect hit, 2 either; returns whether memory was read
  task automatic xlate(input logic [31:0] va, input bit wr, input int mode, output bit miss);
    int m0, acc_cyc, v;
    bit ready_bad;
    logic [31:0] p;
    bit exp_d;
    v = int'(va[31:12]);
    exp_vpn = v;
    m0 = mem_reqs;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    ready_bad = 1'b0;
    while (!rsp_valid) begin
      if (req_ready) ready_bad = 1'b1;
      @(negedge clk);
    end
    miss = (mem_reqs != m0);
    if (mode == 0) chk(miss, "R4 expected miss read memory", 64'(miss), 64'd1);
    if (mode == 1) chk(!miss, "R2 hit without memory read", 64'(miss), 64'd0);
    if (!miss) begin
      chk(cyc == acc_cyc + 1, "R2 hit latency", 64'(cyc - acc_cyc), 64'd1);
    end else begin
      chk(cyc == rsp_drive_cyc + 1, "R4 miss latency", 64'(cyc - rsp_drive_cyc), 64'd1);
      chk(!ready_bad, "R10 ready low during walk", 64'(ready_bad), 64'd0);
      chk(mem_reqs == m0 + 1, "R3 single read", 64'(mem_reqs - m0), 64'd1);
    end
    p = pte_of(v);
    if (p[31]) begin
      exp_d = miss ? (p[30] | wr) : (dmod[v] | wr);
      dmod[v] = exp_d;
      chk(!rsp_fault, "R4 no fault", 64'(rsp_fault), 64'd0);
      chk(rsp_paddr == {p[19:0], va[11:0]}, "R1 physical address", 64'(rsp_paddr),
          64'({p[19:0], va[11:0]}));
      chk(rsp_ref, "R6 used flag", 64'(rsp_ref), 64'd1);
      chk(rsp_dirty == exp_d, "R6 modified flag", 64'(rsp_dirty), 64'(exp_d));
    end else begin
      chk(rsp_fault, "R5 fault raised", 64'(rsp_fault), 64'd1);
      chk(rsp_paddr == '0 && !rsp_ref && !rsp_dirty, "R5 fault fields zero",
          64'({rsp_paddr, rsp_ref, rsp_dirty}), 64'd0);
    end
  endtask

  task automatic write_base(input logic [31:0] b);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = b;
    #1;
    chk(!req_ready, "R9 ready low on base write", 64'(req_ready), 64'd0);
    @(negedge clk);
    base_wr_en = 1'b0;
    exp_base = b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit m;
    int misses;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R11 reset state
    chk(req_ready && !rsp_valid && !mem_req_valid, "R11 reset outputs",
        64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);
    write_base(32'h0040_0000);

    // R7 fill eight empty slots, offsets swept
    for (int v = 1; v <= 8; v++) xlate({20'(v), 12'(v * 291)}, 1'b0, 0, m);
    // R7 all resident; R6 writes on even vpns
    for (int v = 1; v <= 8; v++) xlate({20'(v), 12'hFFF - 12'(v)}, bit'(v % 2 == 0), 1, m);
    for (int v = 1; v <= 8; v++) xlate({20'(v), 12'(v)}, 1'b0, 1, m);

    // R5 absent entry faults and is not installed
    xlate({20'd10, 12'h123}, 1'b0, 0, m);
    xlate({20'd10, 12'h456}, 1'b1, 0, m);

    // R8 install into a full buffer
    xlate({20'd20, 12'hABC}, 1'b1, 0, m);
    xlate({20'd20, 12'h001}, 1'b0, 1, m);
    misses = 0;
    for (int v = 1; v <= 8; v++) begin
      xlate({20'(v), 12'h800}, 1'b0, 2, m);
      if (m) misses++;
    end
    chk(misses >= 1, "R8 one resident entry replaced", 64'(misses), 64'd1);

    // R9 context switch flushes and moves the table
    write_base(32'h0080_0000);
    xlate({20'd20, 12'h010}, 1'b0, 0, m);
    xlate({20'd20, 12'h020}, 1'b0, 1, m);
    xlate({20'd3, 12'h030}, 1'b0, 0, m);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule